// File: doc/BRIEF.md
# I2C Block-Transfer Configuration Register Slave

This block is a serial-bus target that keeps six 8-bit configuration registers for a clock generator. Their contents go out in parallel to the output-control logic. A host loads the registers with one block write. The write starts with the address byte, then a command byte and a byte-count byte, which are both acknowledged and then dropped. Data bytes then fill register 0 upward. A host reads the registers with a block read, which returns a byte count followed by every register in order.

The bus lines come into the system clock through a two-flop synchronizer. All protocol decisions are made on the oversampled lines: START and STOP detection, address matching, acknowledge generation and data shifting. The block never stretches the clock. It pulls SDA low through an output enable. The board supplies the pull-up, and the bus pins are an open-drain wired-AND.

Top module: `cfgslv_top`

## Requirements
- R1: After a synchronous reset the register outputs hold register 0 = 0x07 (bits 2:0 set, bits 7:3 clear), registers 1 and 2 = 0xFF, and registers 3, 4 and 5 = 0x00. SDA is released.
- R2: Only the address bytes 0xD2 (write) and 0xD3 (read) are acknowledged, which is the 7-bit address 0x69 with the direction in bit 0. Any other address gets no acknowledge, and the block then stays off the bus until the next START.
- R3: In a write, the byte after the address (command) and the byte after that (count) are both acknowledged. Their values have no effect on any register.
- R4: Write data bytes, MSB first, are stored in order into registers 0 to 5 and each one is acknowledged. Register k appears on `cfg_o[8k+7:8k]`.
- R5: A STOP after any complete data byte ends the write. Registers already written keep their new values, the others are unchanged, and the registers never change except through an accepted data byte.
- R6: A read returns the byte count 6 first, then registers 0 to 5 in order, each MSB first. The next byte is sent only after the host acknowledges.
- R7: Register 1 bits 6:4 are stored and driven on `cfg_o` exactly as written, but they read back inverted over the bus. The other bits of register 1 read back as stored.
- R8: In a write, a data byte beyond register 5 gets no acknowledge and is discarded.
- R9: A read that continues past register 5 returns 0xFF. A host no-acknowledge ends the read, and SDA is released.
- R10: A repeated START inside a transfer abandons it and restarts at the address byte. SDA is released at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus (wired-AND value) |
| sda_oe_o | output | 1 | When high, the pad pulls SDA low |
| cfg_o | output | 48 | The six registers in parallel, register k in bits 8k+7:8k |

## Verification
The bench goes after four corner cases: a write that overruns register 5, a read that overruns it, a partial write cut short by STOP, and a repeated START between the command byte and a read. A design with an off-by-one in the data index would write the overrun byte into some register or acknowledge it. It would also return a stale register instead of 0xFF. Register 1 is read back after a known write, which exposes a design that inverts the stored value instead of only the read path, or that inverts the wrong bits. The cfg outputs are compared against the model on every clock outside the acknowledge windows, so any write triggered by the command byte, the count byte or a foreign address shows up at once.

// File: rtl/cfgslv_pkg.sv
// Shared types for the configuration register slave.
// Assumes: byte-oriented serial bus, 8-bit data, MSB first.
package cfgslv_pkg;

    localparam int BYTE_W  = 8;  // bus byte width
    localparam int HDR_LEN = 2;  // command and count bytes that precede data

    typedef enum logic [2:0] {
        PS_IDLE,    // off the bus, waiting for START
        PS_RX,      // shifting a byte in from the host
        PS_RX_ACK,  // driving acknowledge for a received byte
        PS_TX,      // shifting a byte out to the host
        PS_TX_ACK   // sampling the host acknowledge
    } proto_state_t;

endpackage

// File: rtl/cfgslv_sync.sv
// Line front end: synchronizes SCL and SDA into the system clock domain and
// derives SCL edges plus START/STOP conditions from the synchronized lines.
// Assumes: the system clock is many times faster than the bus clock, and
// both lines idle high.
module cfgslv_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_q;
    logic              sda_q;
    logic              scl_s;

    // Synchronizer chains plus one history flop per line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_q    <= scl_pipe[STAGES-1];
            sda_q    <= sda_pipe[STAGES-1];
        end
    end

    // Edge and condition decode on the synchronized lines.
    always_comb begin
        scl_s     = scl_pipe[STAGES-1];
        sda_s     = sda_pipe[STAGES-1];
        scl_rise  = scl_s & ~scl_q;
        scl_fall  = ~scl_s & scl_q;
        start_det = scl_s & scl_q & sda_q & ~sda_s;
        stop_det  = scl_s & scl_q & ~sda_q & sda_s;
    end

endmodule

// File: rtl/cfgslv_regs.sv
// Register file: holds the configuration bytes, takes one byte write per
// cycle and gives a read port for the bus. Selected bits of one register
// read back inverted, while the stored and driven value stays as written.
// Assumes: at most one write per cycle; an out-of-range read index returns
// all ones.
module cfgslv_regs #(
    parameter int                       NUM_REGS = 6,
    parameter int                       IW       = 3,
    parameter logic [NUM_REGS*8-1:0]    DEFAULTS = '0,
    parameter int                       INV_IDX  = 1,
    parameter logic [7:0]               INV_MASK = 8'h70
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [IW-1:0]         wr_idx,
    input  logic [7:0]            wr_data,
    input  logic [IW-1:0]         rd_idx,
    output logic [7:0]            rd_data,
    output logic [NUM_REGS*8-1:0] cfg_o
);

    logic [7:0] regs_q [NUM_REGS];

    // Storage with defaults on reset and indexed byte writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) begin
                regs_q[i] <= DEFAULTS[i*8 +: 8];
            end
        end else if (wr_en) begin
            for (int i = 0; i < NUM_REGS; i++) begin
                if (wr_idx == IW'(i)) begin
                    regs_q[i] <= wr_data;
                end
            end
        end
    end

    // Parallel outputs, one byte lane per register.
    genvar g;
    generate
        for (g = 0; g < NUM_REGS; g++) begin : g_lane
            assign cfg_o[g*8 +: 8] = regs_q[g];
        end
    endgenerate

    // Read mux with inversion mask on the selected register.
    always_comb begin
        rd_data = '1;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_idx == IW'(i)) begin
                rd_data = regs_q[i] ^ ((i == INV_IDX) ? INV_MASK : 8'h00);
            end
        end
    end

endmodule

// File: rtl/cfgslv_proto.sv
// Protocol engine: matches the address, acknowledges the header and data
// bytes, issues register writes in sequence and serialises block reads with
// a leading count byte.
// Assumes: SDA changes only while SCL is low, except for START and STOP,
// and the host never stretches or arbitrates.
module cfgslv_proto
    import cfgslv_pkg::*;
#(
    parameter int         NUM_REGS = 6,
    parameter int         IW       = 3,
    parameter logic [6:0] ADDR7    = 7'h69
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sda_s,
    input  logic          scl_rise,
    input  logic          scl_fall,
    input  logic          start_det,
    input  logic          stop_det,
    input  logic [7:0]    rd_data,
    output logic [IW-1:0] rd_idx,
    output logic          wr_en,
    output logic [IW-1:0] wr_idx,
    output logic [7:0]    wr_data,
    output logic          sda_oe
);

    localparam int RXW      = $clog2(NUM_REGS + HDR_LEN + 1);
    localparam int TX_LAST  = NUM_REGS + 1;

    proto_state_t   state;
    logic [3:0]     bit_cnt;
    logic [7:0]     shreg;
    logic           addr_ph;
    logic           is_read;
    logic           host_ack;
    logic [RXW-1:0] rx_idx;
    logic [RXW-1:0] tx_idx;
    logic [7:0]     tx_byte;

    // Next outgoing byte: the count first, then the register read port.
    always_comb begin
        rd_idx  = IW'(tx_idx - RXW'(1));
        tx_byte = (tx_idx == '0) ? 8'(NUM_REGS) : rd_data;
    end

    // Bus state machine, bit counter, shifter and register write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= PS_IDLE;
            bit_cnt  <= '0;
            shreg    <= '0;
            addr_ph  <= 1'b0;
            is_read  <= 1'b0;
            host_ack <= 1'b0;
            rx_idx   <= '0;
            tx_idx   <= '0;
            wr_en    <= 1'b0;
            wr_idx   <= '0;
            wr_data  <= '0;
            sda_oe   <= 1'b0;
        end else begin
            wr_en <= 1'b0;
            if (start_det) begin
                state   <= PS_RX;
                bit_cnt <= '0;
                addr_ph <= 1'b1;
                rx_idx  <= '0;
                tx_idx  <= '0;
                sda_oe  <= 1'b0;
            end else if (stop_det) begin
                state  <= PS_IDLE;
                sda_oe <= 1'b0;
            end else begin
                case (state)
                    PS_RX: begin
                        if (scl_rise && bit_cnt != 4'd8) begin
                            shreg   <= {shreg[6:0], sda_s};
                            bit_cnt <= bit_cnt + 4'd1;
                        end else if (scl_fall && bit_cnt == 4'd8) begin
                            bit_cnt <= '0;
                            if (addr_ph) begin
                                if (shreg[7:1] == ADDR7) begin
                                    is_read <= shreg[0];
                                    sda_oe  <= 1'b1;
                                    state   <= PS_RX_ACK;
                                end else begin
                                    state <= PS_IDLE;
                                end
                            end else if (rx_idx < RXW'(HDR_LEN)) begin
                                sda_oe <= 1'b1;
                                state  <= PS_RX_ACK;
                                rx_idx <= rx_idx + RXW'(1);
                            end else if (rx_idx < RXW'(HDR_LEN + NUM_REGS)) begin
                                sda_oe  <= 1'b1;
                                state   <= PS_RX_ACK;
                                wr_en   <= 1'b1;
                                wr_idx  <= IW'(rx_idx - RXW'(HDR_LEN));
                                wr_data <= shreg;
                                rx_idx  <= rx_idx + RXW'(1);
                            end else begin
                                state <= PS_IDLE;
                            end
                        end
                    end
                    PS_RX_ACK: begin
                        if (scl_fall) begin
                            addr_ph <= 1'b0;
                            bit_cnt <= '0;
                            if (is_read) begin
                                state  <= PS_TX;
                                shreg  <= tx_byte;
                                sda_oe <= ~tx_byte[7];
                            end else begin
                                state  <= PS_RX;
                                sda_oe <= 1'b0;
                            end
                        end
                    end
                    PS_TX: begin
                        if (scl_fall) begin
                            if (bit_cnt == 4'd7) begin
                                sda_oe <= 1'b0;
                                state  <= PS_TX_ACK;
                            end else begin
                                shreg   <= {shreg[6:0], 1'b0};
                                sda_oe  <= ~shreg[6];
                                bit_cnt <= bit_cnt + 4'd1;
                            end
                        end
                    end
                    PS_TX_ACK: begin
                        if (scl_rise) begin
                            host_ack <= ~sda_s;
                            if (!sda_s && tx_idx != RXW'(TX_LAST)) begin
                                tx_idx <= tx_idx + RXW'(1);
                            end
                        end else if (scl_fall) begin
                            bit_cnt <= '0;
                            if (host_ack) begin
                                state  <= PS_TX;
                                shreg  <= tx_byte;
                                sda_oe <= ~tx_byte[7];
                            end else begin
                                state <= PS_IDLE;
                            end
                        end
                    end
                    default: state <= PS_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/cfgslv_top.sv
// Top of the configuration register slave: line synchronizer, protocol
// engine and register file, wired together.
// Assumes: an open-drain bus; sda_oe_o high pulls SDA low at the pad.
module cfgslv_top #(
    parameter int                    NUM_REGS    = 6,
    parameter logic [6:0]            SLAVE_ADDR  = 7'h69,
    parameter int                    SYNC_STAGES = 2,
    parameter logic [NUM_REGS*8-1:0] DEFAULTS    = 48'h0000_00FF_FF07,
    parameter int                    INV_IDX     = 1,
    parameter logic [7:0]            INV_MASK    = 8'h70
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_oe_o,
    output logic [NUM_REGS*8-1:0] cfg_o
);

    localparam int IW = $clog2(NUM_REGS + 1);

    logic          sda_s;
    logic          scl_rise;
    logic          scl_fall;
    logic          start_det;
    logic          stop_det;
    logic [7:0]    rd_data;
    logic [IW-1:0] rd_idx;
    logic          wr_en;
    logic [IW-1:0] wr_idx;
    logic [7:0]    wr_data;

    cfgslv_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    cfgslv_proto #(
        .NUM_REGS (NUM_REGS),
        .IW       (IW),
        .ADDR7    (SLAVE_ADDR)
    ) proto_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .rd_data   (rd_data),
        .rd_idx    (rd_idx),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .sda_oe    (sda_oe_o)
    );

    cfgslv_regs #(
        .NUM_REGS (NUM_REGS),
        .IW       (IW),
        .DEFAULTS (DEFAULTS),
        .INV_IDX  (INV_IDX),
        .INV_MASK (INV_MASK)
    ) regs_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .rd_idx  (rd_idx),
        .rd_data (rd_data),
        .cfg_o   (cfg_o)
    );

endmodule

// File: rtl/cfgslv_chk.sv
// Property checker for cfgslv_top, attached through bind below.
// Assumes: the bus host keeps SCL low for several system clocks.
module cfgslv_chk #(
    parameter int                    NUM_REGS = 6,
    parameter int                    IW       = 3,
    parameter logic [NUM_REGS*8-1:0] DEFAULTS = '0
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  scl_i,
    input logic                  sda_oe_o,
    input logic [NUM_REGS*8-1:0] cfg_o,
    input logic                  start_det,
    input logic                  stop_det,
    input logic                  wr_en,
    input logic [IW-1:0]         wr_idx
);

    logic rst_low_q;

    // Remembers that the previous edge saw reset asserted.
    always_ff @(posedge clk) rst_low_q <= !rst_n;

    // R1: one cycle after reset the registers sit at their defaults.
    always @(posedge clk) begin
        if (rst_low_q) begin
            assert_reset_defaults_R1: assert (cfg_o == DEFAULTS)
                else $error("reset defaults not loaded");
        end
    end

    assert_cfg_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(cfg_o));

    assert_wr_in_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_idx < IW'(NUM_REGS)));

    assert_oe_rise_scl_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe_o) |-> !scl_i);

    assert_oe_fall_scl_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_oe_o) |-> (!scl_i || $past(start_det || stop_det)));

    assert_start_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> !sda_oe_o);

    assert_stop_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe_o);

endmodule

bind cfgslv_top cfgslv_chk #(
    .NUM_REGS (NUM_REGS),
    .IW       (IW),
    .DEFAULTS (DEFAULTS)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_oe_o  (sda_oe_o),
    .cfg_o     (cfg_o),
    .start_det (start_det),
    .stop_det  (stop_det),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx)
);

// File: tb/cfgslv_top_tb_top.sv
// Bench for cfgslv_top: a behavioural bus host, a register model updated at
// each accepted data byte, and a compare of cfg_o against the model on every
// clock outside the acknowledge windows.
module cfgslv_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int Q          = 5;   // quarter bus bit, in system clocks
    localparam int NREG       = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_scl = 1'b1;
    logic        host_sda = 1'b1;
    logic        sda_line;
    logic        sda_oe_o;
    logic [47:0] cfg_o;

    int   n_checks = 0;
    int   n_err    = 0;
    bit   hold     = 1'b1;
    bit   done     = 1'b0;
    logic [7:0] model [NREG];
    logic [7:0] wbuf  [8];

    assign sda_line = host_sda & ~sda_oe_o;

    cfgslv_top dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (host_scl),
        .sda_i    (sda_line),
        .sda_oe_o (sda_oe_o),
        .cfg_o    (cfg_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [47:0] model_flat();
        logic [47:0] f;
        for (int i = 0; i < NREG; i++) f[i*8 +: 8] = model[i];
        return f;
    endfunction

    task automatic check(input string tag, input logic [47:0] act, input logic [47:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic bus_start();
        host_sda = 1'b1; wait_clk(Q);
        host_scl = 1'b1; wait_clk(Q);
        host_sda = 1'b0; wait_clk(Q);
        host_scl = 1'b0; wait_clk(Q);
    endtask

    task automatic bus_stop();
        host_sda = 1'b0; wait_clk(Q);
        host_scl = 1'b1; wait_clk(Q);
        host_sda = 1'b1; wait_clk(2*Q);
    endtask

    task automatic write_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            wait_clk(Q); host_sda = b[i];
            wait_clk(Q); host_scl = 1'b1;
            wait_clk(2*Q); host_scl = 1'b0;
        end
        wait_clk(Q); host_sda = 1'b1;
        wait_clk(Q); host_scl = 1'b1;
        wait_clk(Q); acked = !sda_line;
        wait_clk(Q); host_scl = 1'b0;
    endtask

    task automatic read_byte(input bit give_ack, output logic [7:0] v);
        host_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wait_clk(2*Q); host_scl = 1'b1;
            wait_clk(Q); v[i] = sda_line;
            wait_clk(Q); host_scl = 1'b0;
        end
        wait_clk(Q); host_sda = give_ack ? 1'b0 : 1'b1;
        wait_clk(Q); host_scl = 1'b1;
        wait_clk(2*Q); host_scl = 1'b0;
        wait_clk(Q); host_sda = 1'b1;
    endtask

    // Block write: address, command, count, then n data bytes from wbuf.
    task automatic wr_txn(input logic [7:0] addr_b, input logic [7:0] cmd,
                          input logic [7:0] cnt, input int n);
        bit a;
        bus_start();
        write_byte(addr_b, a);
        check("R2 address ack", a, (addr_b == 8'hD2));
        if (a) begin
            write_byte(cmd, a);
            check("R3 command ack", a, 1);
            write_byte(cnt, a);
            check("R3 count ack", a, 1);
            for (int i = 0; i < n; i++) begin
                hold = 1'b1;
                write_byte(wbuf[i], a);
                if (i < NREG) check("R4 data ack", a, 1);
                else          check("R8 overflow nack", a, 0);
                wait_clk(2);
                if (i < NREG) model[i] = wbuf[i];
                hold = 1'b0;
            end
        end
        bus_stop();
    endtask

    // Block read of nb bytes; the last one is not acknowledged.
    task automatic rd_txn(input logic [7:0] addr_b, input int nb);
        bit a;
        logic [7:0] v;
        logic [7:0] e;
        bus_start();
        write_byte(addr_b, a);
        check("R2 read address ack", a, (addr_b == 8'hD3));
        if (a) begin
            for (int k = 0; k < nb; k++) begin
                read_byte(k < nb - 1, v);
                if (k == 0)          e = 8'd6;
                else if (k <= NREG)  e = model[k-1] ^ ((k == 2) ? 8'h70 : 8'h00);
                else                 e = 8'hFF;
                if (k == 0)          check("R6 count byte", v, e);
                else if (k == 2)     check("R7 inverted readback", v, e);
                else if (k <= NREG)  check("R6 register readback", v, e);
                else                 check("R9 past-end 0xFF", v, e);
            end
            wait_clk(Q);
            check("R9 released after host nack", sda_oe_o, 0);
        end
        bus_stop();
    endtask

    // Every-clock compare of the parallel outputs against the model.
    always @(negedge clk) begin
        if (rst_n && !hold && !done) check("R5 cfg tracks model", cfg_o, model_flat());
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            done = 1'b1;
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_checks + 1);
            $finish;
        end
    end

    initial begin
        bit a;
        model[0] = 8'h07; model[1] = 8'hFF; model[2] = 8'hFF;
        model[3] = 8'h00; model[4] = 8'h00; model[5] = 8'h00;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(2);
        // R1: defaults and released line
        check("R1 reset defaults", cfg_o, 48'h0000_00FF_FF07);
        check("R1 sda released", sda_oe_o, 0);
        hold = 1'b0;

        // R2: foreign write address is ignored
        wr_txn(8'hA4, 8'h00, 8'h00, 0);
        check("R2 no change after foreign address", cfg_o, model_flat());

        // R3/R4: full write, then R6/R7/R9 read past the end
        wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
        wbuf[3] = 8'h44; wbuf[4] = 8'h55; wbuf[5] = 8'h66;
        wr_txn(8'hD2, 8'h5A, 8'h33, 6);
        check("R4 all registers written", cfg_o, 48'h6655_4433_2211);
        check("R7 stored value not inverted", cfg_o[15:8], 8'h22);
        rd_txn(8'hD3, 9);

        // R5: partial write with different header values (R3 ignored)
        wbuf[0] = 8'hA5; wbuf[1] = 8'h0F;
        wr_txn(8'hD2, 8'h00, 8'hFF, 2);
        check("R5 partial write keeps rest", cfg_o, 48'h6655_4433_0FA5);

        // R8: overflow bytes are refused
        for (int i = 0; i < 8; i++) wbuf[i] = 8'(i + 1);
        wr_txn(8'hD2, 8'h01, 8'h08, 8);
        check("R8 overflow discarded", cfg_o, 48'h0605_0403_0201);

        // R10: repeated START after the command byte, then a short read
        bus_start();
        write_byte(8'hD2, a);
        check("R10 write address ack", a, 1);
        write_byte(8'h77, a);
        check("R10 command ack", a, 1);
        rd_txn(8'hD3, 3);
        check("R10 no write from aborted transfer", cfg_o, 48'h0605_0403_0201);

        // R2: foreign read address
        rd_txn(8'hD5, 1);
        check("R2 sda released after foreign read", sda_oe_o, 0);

        wait_clk(10);
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

endmodule